// File: doc/BRIEF.md
# Linked-Descriptor DMA Chain Walker

This block is the sequencing engine of one DMA channel. It follows a linked list of descriptors held in host memory. Software loads the address of the first descriptor into a pointer register pair. It then writes the control/status word with enable, scatter-gather mode and start set together. From then on the engine works alone. It fetches each 32-byte descriptor as eight 32-bit beats over a read port. It hands the transfer described there to a data mover through a request/acknowledge handshake. It then moves on to the descriptor named by the link word.

The low bits of every link word are flags. They state whether the walk ends after this descriptor and whether finishing it raises an interrupt. They also give the direction of the next hop, so each link decides how its successor moves data. A link may point back to an earlier descriptor. That forms a ring, which runs until software aborts it. The engine adds up the byte counts of the descriptors it finishes and reports done when it stops.

Top module: `sgdma_walker`

## Requirements
- R1: After reset the control/status word (byte offset 0x60) and the byte total (0x64) read 0, the interrupt line is low, and neither the fetch request nor the transfer request is asserted.
- R2: A write to 0x60 with bits 0 (enable), 1 (start) and 8 (scatter-gather mode) all set, while the engine is idle, starts a walk. The walk begins at the descriptor address formed from the pointer high word at 0x54 (bits 63:32) and the pointer low word at 0x50 with its low 5 bits cleared. The same write clears done (bit 4) and the byte total. Both pointer words read back as written.
- R3: Each descriptor is fetched with one read request whose address is 32-byte aligned. The request and its address stay stable until accepted. Eight response beats follow, in this word order: host address low, host address high, local word, reserved, byte count, reserved, link low, link high.
- R4: Only after all eight beats have arrived does the engine raise a transfer request. The request carries the 64-bit host address, the local word and the byte count, and all of them stay stable until acknowledged.
- R5: A descriptor's direction output (1 = toward host) is bit 3 of the link word that led to it. For the first descriptor this is bit 3 of the pointer low word.
- R6: A descriptor with a byte count of zero raises no transfer request. It completes at once, and the walk goes on to its link.
- R7: When the finished descriptor's link low word has bit 1 (end of chain) set, the engine stops, sets done, and issues no further requests.
- R8: When the finished descriptor's link low word has bit 2 set, control/status bit 5 is set and the interrupt line goes high. Both stay high until software writes 1 to bit 5.
- R9: The byte total at 0x64 grows by the byte count of each finished descriptor. It can be read at any time without stalling the walk.
- R10: A link without end of chain that points back to an earlier descriptor makes the engine cycle through the ring until aborted.
- R11: Writing 0x60 with bit 2 (abort) stops the walk. A pending transfer request is withdrawn, or a descriptor fetch in progress is drained first. Done then reads 1. An abort while idle also sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| mem_req_valid | output | 1 | Descriptor fetch request |
| mem_req_addr | output | 64 | Descriptor address, 32-byte aligned |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_rsp_valid | input | 1 | Descriptor beat valid |
| mem_rsp_data | input | 32 | Descriptor beat data |
| xfer_valid | output | 1 | Transfer request to the data mover |
| xfer_host_addr | output | 64 | Host address of the transfer |
| xfer_local | output | 32 | Local word of the descriptor |
| xfer_bytes | output | 32 | Byte count of the transfer |
| xfer_to_host | output | 1 | 1 = write toward host, 0 = read from host |
| xfer_ack | input | 1 | Transfer finished |
| irq | output | 1 | Interrupt line, follows control/status bit 5 |

## Verification
On every cycle the assertions check the handshake rules at both edges. Fetch requests must stay stable and aligned, transfer requests must stay stable until acknowledged, no zero-length transfer may be issued, and done may never be set while the engine is still walking. The bench's scenarios are the only way to show the things that depend on memory contents: the order of transfers along a chain, the direction each link hands to its successor, the byte total, interrupts from flagged links, rings running until aborted, and the clearing effect of a fresh start.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int DESC_BEATS = 8;
  localparam int HOST_AW    = 64;
  localparam int WORD_W     = 32;
  localparam int ALIGN_BITS = 5;

  // link word flag positions
  localparam int LNK_EOC = 1;
  localparam int LNK_IRQ = 2;
  localparam int LNK_DIR = 3;

  // control/status bit positions
  localparam int CS_EN   = 0;
  localparam int CS_GO   = 1;
  localparam int CS_STOP = 2;
  localparam int CS_DONE = 4;
  localparam int CS_IRQ  = 5;
  localparam int CS_SG   = 8;

  typedef enum logic [2:0] {
    W_IDLE, W_REQ, W_BEATS, W_EVAL, W_XFER, W_FINISH, W_HALT
  } walk_state_t;

  typedef struct packed {
    logic [HOST_AW-1:0] host_addr;
    logic [WORD_W-1:0]  local_word;
    logic [WORD_W-1:0]  byte_count;
    logic [HOST_AW-1:0] link;
  } desc_t;
endpackage

// File: rtl/sgdma_fetch.sv
module sgdma_fetch
  import sgdma_pkg::*;
#(
  parameter int BEATS = DESC_BEATS,
  parameter int DW    = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          accept,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          last_beat,
  output desc_t         desc
);
  localparam int CW = $clog2(BEATS);

  logic [CW-1:0] beat_cnt;
  logic [DW-1:0] words [BEATS];

  assign last_beat = accept && rsp_valid && (beat_cnt == CW'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      beat_cnt <= '0;
    end else if (accept && rsp_valid) begin
      beat_cnt <= beat_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && rsp_valid) begin
      words[beat_cnt] <= rsp_data;
    end
  end

  assign desc.host_addr  = {words[1], words[0]};
  assign desc.local_word = words[2];
  assign desc.byte_count = words[4];
  assign desc.link       = {words[7], words[6]};
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int AW = HOST_AW,
  parameter int AL = ALIGN_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] first_ptr,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  output logic          beat_accept,
  output logic          fetch_restart,
  input  logic          last_beat,
  input  desc_t         desc,
  output logic          xfer_valid,
  output logic          xfer_to_host,
  input  logic          xfer_ack,
  output logic          done_set,
  output logic          irq_set,
  output logic          add_valid,
  output logic [WORD_W-1:0] add_bytes,
  output logic          idle
);
  walk_state_t   state;
  logic [AW-1:0] cur_ptr;
  logic          cur_dir;
  logic          abort_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= W_IDLE;
      cur_ptr <= '0;
      cur_dir <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (abort && state != W_IDLE) abort_q <= 1'b1;
      case (state)
        W_IDLE: begin
          if (start) begin
            cur_ptr <= {first_ptr[AW-1:AL], {AL{1'b0}}};
            cur_dir <= first_ptr[LNK_DIR];
            abort_q <= 1'b0;
            state   <= W_REQ;
          end else if (abort) begin
            state <= W_HALT;
          end
        end
        W_REQ:   if (mem_req_ready) state <= W_BEATS;
        W_BEATS: if (last_beat) state <= W_EVAL;
        W_EVAL: begin
          if (abort_q)                   state <= W_HALT;
          else if (desc.byte_count == 0) state <= W_FINISH;
          else                           state <= W_XFER;
        end
        W_XFER: begin
          if (xfer_ack)     state <= W_FINISH;
          else if (abort_q) state <= W_HALT;
        end
        W_FINISH: begin
          if (desc.link[LNK_EOC] || abort_q) begin
            state <= W_HALT;
          end else begin
            cur_ptr <= {desc.link[AW-1:AL], {AL{1'b0}}};
            cur_dir <= desc.link[LNK_DIR];
            state   <= W_REQ;
          end
        end
        W_HALT: begin
          abort_q <= 1'b0;
          state   <= W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == W_REQ);
  assign mem_req_addr  = cur_ptr;
  assign fetch_restart = (state == W_REQ) && mem_req_ready;
  assign beat_accept   = (state == W_BEATS);
  assign xfer_valid    = (state == W_XFER);
  assign xfer_to_host  = cur_dir;
  assign add_valid     = (state == W_FINISH);
  assign add_bytes     = desc.byte_count;
  assign irq_set       = (state == W_FINISH) && desc.link[LNK_IRQ];
  assign done_set      = (state == W_HALT);
  assign idle          = (state == W_IDLE);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R3
  req_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[AL-1:0] == '0);

  // R4
  xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && !xfer_ack && !abort_q |=> xfer_valid && $stable(desc.byte_count)
      && $stable(desc.host_addr) && $stable(xfer_to_host));

  // R6
  xfer_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> desc.byte_count != '0);
endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int RAW = 8,
  parameter int DW  = WORD_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           walker_idle,
  input  logic           done_set,
  input  logic           irq_set,
  input  logic           add_valid,
  input  logic [DW-1:0]  add_bytes,
  output logic           start_pulse,
  output logic           abort_pulse,
  output logic [2*DW-1:0] first_ptr,
  output logic           irq_line
);
  localparam logic [RAW-1:0] A_PTR_LO = RAW'('h50);
  localparam logic [RAW-1:0] A_PTR_HI = RAW'('h54);
  localparam logic [RAW-1:0] A_CTRL   = RAW'('h60);
  localparam logic [RAW-1:0] A_TOTAL  = RAW'('h64);

  logic [DW-1:0] ptr_lo, ptr_hi, total_q;
  logic          en_q, sg_q, done_q, irq_q;
  logic          ctrl_wr;

  assign ctrl_wr     = reg_we && (reg_addr == A_CTRL);
  assign start_pulse = ctrl_wr && walker_idle && reg_wdata[CS_EN]
                       && reg_wdata[CS_GO] && reg_wdata[CS_SG];
  assign abort_pulse = ctrl_wr && reg_wdata[CS_STOP];
  assign first_ptr   = {ptr_hi, ptr_lo};
  assign irq_line    = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_lo  <= '0;
      ptr_hi  <= '0;
      total_q <= '0;
      en_q    <= 1'b0;
      sg_q    <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_PTR_LO) ptr_lo <= reg_wdata;
      if (reg_we && reg_addr == A_PTR_HI) ptr_hi <= reg_wdata;
      if (ctrl_wr) begin
        en_q <= reg_wdata[CS_EN];
        sg_q <= reg_wdata[CS_SG];
      end
      if (start_pulse)   done_q <= 1'b0;
      else if (done_set) done_q <= 1'b1;
      if (irq_set)                           irq_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[CS_IRQ]) irq_q <= 1'b0;
      if (start_pulse)    total_q <= '0;
      else if (add_valid) total_q <= total_q + add_bytes;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_PTR_LO: reg_rdata <= ptr_lo;
        A_PTR_HI: reg_rdata <= ptr_hi;
        A_CTRL: begin
          reg_rdata          <= '0;
          reg_rdata[CS_EN]   <= en_q;
          reg_rdata[CS_DONE] <= done_q;
          reg_rdata[CS_IRQ]  <= irq_q;
          reg_rdata[CS_SG]   <= sg_q;
        end
        A_TOTAL: reg_rdata <= total_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> walker_idle);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq_line && !(ctrl_wr && reg_wdata[CS_IRQ]) |=> irq_line);
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int RAW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [RAW-1:0]     reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               mem_req_valid,
  output logic [HOST_AW-1:0] mem_req_addr,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [WORD_W-1:0]  mem_rsp_data,
  output logic               xfer_valid,
  output logic [HOST_AW-1:0] xfer_host_addr,
  output logic [WORD_W-1:0]  xfer_local,
  output logic [WORD_W-1:0]  xfer_bytes,
  output logic               xfer_to_host,
  input  logic               xfer_ack,
  output logic               irq
);
  logic                start_pulse, abort_pulse, walker_idle;
  logic                done_set, irq_set, add_valid;
  logic [WORD_W-1:0]   add_bytes;
  logic [HOST_AW-1:0]  first_ptr;
  logic                beat_accept, fetch_restart, last_beat;
  desc_t               desc;

  sgdma_regs #(.RAW(RAW), .DW(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .walker_idle(walker_idle),
    .done_set(done_set), .irq_set(irq_set), .add_valid(add_valid),
    .add_bytes(add_bytes), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
    .first_ptr(first_ptr), .irq_line(irq)
  );

  sgdma_fetch #(.BEATS(DESC_BEATS), .DW(WORD_W)) u_fetch (
    .clk(clk), .rst(rst), .restart(fetch_restart), .accept(beat_accept),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .last_beat(last_beat), .desc(desc)
  );

  sgdma_seq #(.AW(HOST_AW), .AL(ALIGN_BITS)) u_seq (
    .clk(clk), .rst(rst), .start(start_pulse), .abort(abort_pulse),
    .first_ptr(first_ptr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .beat_accept(beat_accept), .fetch_restart(fetch_restart),
    .last_beat(last_beat), .desc(desc), .xfer_valid(xfer_valid),
    .xfer_to_host(xfer_to_host), .xfer_ack(xfer_ack), .done_set(done_set),
    .irq_set(irq_set), .add_valid(add_valid), .add_bytes(add_bytes),
    .idle(walker_idle)
  );

  assign xfer_host_addr = desc.host_addr;
  assign xfer_local     = desc.local_word;
  assign xfer_bytes     = desc.byte_count;
endmodule

// File: tb/sim_sgdma_walker.sv
module sim_sgdma_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'h0;
  logic        xfer_valid;
  logic [63:0] xfer_host_addr;
  logic [31:0] xfer_local, xfer_bytes;
  logic        xfer_to_host;
  logic        xfer_ack = 1'b0;
  logic        irq;

  always #5 clk = ~clk;

  sgdma_walker u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .xfer_valid(xfer_valid),
    .xfer_host_addr(xfer_host_addr), .xfer_local(xfer_local),
    .xfer_bytes(xfer_bytes), .xfer_to_host(xfer_to_host),
    .xfer_ack(xfer_ack), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] mem [256];
  logic [31:0] expect_hi = 32'h0;

  logic [63:0] lg_host [64];
  logic [31:0] lg_local [64];
  logic [31:0] lg_bytes [64];
  logic        lg_dir [64];
  int          log_n = 0;

  logic [63:0] ex_host [8];
  logic [31:0] ex_local [8];
  logic [31:0] ex_bytes [8];
  logic        ex_dir [8];
  int          ex_n;
  logic [31:0] ex_sum;
  logic        ex_irq;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // transfer monitor
  always @(posedge clk) begin
    if (!rst && xfer_valid && xfer_ack && log_n < 64) begin
      lg_host[log_n]  <= xfer_host_addr;
      lg_local[log_n] <= xfer_local;
      lg_bytes[log_n] <= xfer_bytes;
      lg_dir[log_n]   <= xfer_to_host;
      log_n           <= log_n + 1;
    end
  end

  // descriptor memory responder
  int          m_wait;
  logic [63:0] m_addr;
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid && !rst) begin
        m_wait = $urandom % 3;
        repeat (m_wait) @(negedge clk);
        mem_req_ready = 1'b1;
        m_addr = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R2", "fetch address high word", {32'h0, m_addr[63:32]}, {32'h0, expect_hi});
        for (int k = 0; k < 8; k++) begin
          m_wait = $urandom % 2;
          repeat (m_wait) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[{m_addr[9:5], 3'b000} + k];
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  // data mover model
  int   a_wait;
  logic a_ok;
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_valid) begin
        a_wait = $urandom % 4;
        a_ok = 1'b1;
        repeat (a_wait) begin
          @(negedge clk);
          if (!xfer_valid) a_ok = 1'b0;
        end
        if (a_ok && xfer_valid) begin
          xfer_ack = 1'b1;
          @(negedge clk);
          xfer_ack = 1'b0;
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic put_desc(input int slot, input logic [63:0] host, input logic [31:0] loc,
                          input logic [31:0] bytes, input logic [31:0] nlo, input logic [31:0] nhi);
    mem[slot*8+0] = host[31:0];
    mem[slot*8+1] = host[63:32];
    mem[slot*8+2] = loc;
    mem[slot*8+3] = 32'h0;
    mem[slot*8+4] = bytes;
    mem[slot*8+5] = 32'h0;
    mem[slot*8+6] = nlo;
    mem[slot*8+7] = nhi;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(8'h60, v);
      if (v[4]) break;
    end
  endtask

  task automatic compare_log(input string req, input int base);
    chk(req, "transfer count", 64'(log_n - base), 64'(ex_n));
    for (int i = 0; i < ex_n; i++) begin
      if (base + i < log_n) begin
        chk(req, "host address", lg_host[base+i], ex_host[i]);
        chk(req, "local word", {32'h0, lg_local[base+i]}, {32'h0, ex_local[i]});
        chk(req, "byte count", {32'h0, lg_bytes[base+i]}, {32'h0, ex_bytes[i]});
        chk("R5", "direction", {63'h0, lg_dir[base+i]}, {63'h0, ex_dir[i]});
      end
    end
  endtask

  task automatic random_chain();
    int base, n, slot, nslot, first_dir, prev_dir, dn, iq, lastf, lbase;
    logic [63:0] host;
    logic [31:0] bytes, nlo, v;
    n = 1 + ($urandom % 5);
    base = $urandom % 32;
    first_dir = $urandom % 2;
    prev_dir = first_dir;
    ex_n = 0; ex_sum = 0; ex_irq = 1'b0;
    for (int k = 0; k < n; k++) begin
      slot  = (base + k*7) % 32;
      nslot = (base + (k+1)*7) % 32;
      host  = {$urandom, $urandom & 32'hFFFF_FFFC};
      bytes = ($urandom % 4 == 0) ? 32'h0 : 32'(((($urandom % 256) + 1)) * 4);
      dn = $urandom % 2;
      iq = $urandom % 2;
      lastf = (k == n-1) ? 1 : 0;
      nlo = (lastf != 0 ? 32'h0 : 32'(nslot << 5)) | 32'(dn << 3) | 32'(iq << 2) | 32'(lastf << 1);
      put_desc(slot, host, $urandom, bytes, nlo, 32'h0);
      if (bytes != 0) begin
        ex_host[ex_n]  = host;
        ex_local[ex_n] = mem[slot*8+2];
        ex_bytes[ex_n] = bytes;
        ex_dir[ex_n]   = prev_dir[0];
        ex_n++;
      end
      ex_sum += bytes;
      if (iq != 0) ex_irq = 1'b1;
      prev_dir = dn;
    end
    wr(8'h60, 32'h20);
    lbase = log_n;
    wr(8'h50, 32'(base << 5) | 32'(first_dir << 3));
    wr(8'h54, 32'h0);
    wr(8'h60, 32'h103);
    wait_done();
    compare_log("R4", lbase);
    rd(8'h64, v);
    chk("R9", "random chain byte total", {32'h0, v}, {32'h0, ex_sum});
    rd(8'h60, v);
    chk("R7", "random chain done", {63'h0, v[4]}, 64'h1);
    chk("R8", "random chain irq bit", {63'h0, v[5]}, {63'h0, ex_irq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lbase, cnt;
    logic [31:0] sum;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h60, v);
    chk("R1", "control word after reset", {32'h0, v}, 64'h0);
    rd(8'h64, v);
    chk("R1", "byte total after reset", {32'h0, v}, 64'h0);
    chk("R1", "irq after reset", {63'h0, irq}, 64'h0);
    chk("R1", "no requests after reset", {62'h0, mem_req_valid, xfer_valid}, 64'h0);

    // R11 abort while idle sets done
    wr(8'h60, 32'h4);
    rd(8'h60, v);
    chk("R11", "abort while idle sets done", {63'h0, v[4]}, 64'h1);

    // directed chain with zero-length middle descriptor and high word
    expect_hi = 32'hAB;
    put_desc(2, 64'h0000_0012_0000_1000, 32'h1111_1111, 32'h100, (9 << 5) | 8, 32'hAB);
    put_desc(9, 64'h0000_0034_0000_2000, 32'h0, 32'h0, (5 << 5) | 8 | 4, 32'hAB);
    put_desc(5, 64'h0000_0056_0000_3000, 32'h2222_2222, 32'h40, 32'h2 | 32'h4, 32'hAB);
    ex_n = 2;
    ex_host[0] = 64'h0000_0012_0000_1000; ex_local[0] = 32'h1111_1111; ex_bytes[0] = 32'h100; ex_dir[0] = 1'b0;
    ex_host[1] = 64'h0000_0056_0000_3000; ex_local[1] = 32'h2222_2222; ex_bytes[1] = 32'h40;  ex_dir[1] = 1'b1;
    lbase = log_n;
    wr(8'h50, 32'h40 | 32'h7);
    wr(8'h54, 32'hAB);
    rd(8'h50, v);
    chk("R2", "pointer low readback", {32'h0, v}, 64'h47);
    rd(8'h54, v);
    chk("R2", "pointer high readback", {32'h0, v}, 64'hAB);
    wr(8'h60, 32'h103);
    wait_done();
    compare_log("R6", lbase);
    rd(8'h64, v);
    chk("R9", "directed byte total", {32'h0, v}, 64'h140);
    rd(8'h60, v);
    chk("R7", "directed done", {63'h0, v[4]}, 64'h1);
    chk("R2", "enable and mode readback", {62'h0, v[8], v[0]}, 64'h3);
    chk("R8", "irq bit set by flagged link", {63'h0, v[5]}, 64'h1);
    chk("R8", "irq line high", {63'h0, irq}, 64'h1);
    repeat (20) @(negedge clk);
    chk("R7", "no transfers after end of chain", 64'(log_n - lbase), 64'h2);
    wr(8'h60, 32'h20);
    rd(8'h60, v);
    chk("R8", "irq bit cleared by write of one", {63'h0, v[5]}, 64'h0);
    chk("R8", "irq line low after clear", {63'h0, irq}, 64'h0);

    // R2 new start clears done and byte total
    wr(8'h60, 32'h103);
    rd(8'h64, v);
    chk("R2", "byte total cleared by start", {32'h0, v}, 64'h0);
    rd(8'h60, v);
    chk("R2", "done cleared by start", {63'h0, v[4]}, 64'h0);
    wait_done();
    rd(8'h64, v);
    chk("R9", "byte total after rerun", {32'h0, v}, 64'h140);

    // R10 ring until abort
    expect_hi = 32'h0;
    put_desc(0, 64'h0000_0001_0000_A000, 32'hA, 32'h20, (1 << 5) | 8, 32'h0);
    put_desc(1, 64'h0000_0002_0000_B000, 32'hB, 32'h30, 32'h4, 32'h0);
    wr(8'h60, 32'h20);
    lbase = log_n;
    wr(8'h50, 32'h0);
    wr(8'h54, 32'h0);
    wr(8'h60, 32'h103);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (log_n - lbase >= 6) break;
    end
    rd(8'h64, v);
    chk("R9", "byte total readable mid-walk", {63'h0, (v >= 32'h20)}, 64'h1);
    wr(8'h60, 32'h4);
    wait_done();
    cnt = log_n - lbase;
    chk("R10", "ring ran at least six hops", {63'h0, (cnt >= 6)}, 64'h1);
    for (int i = 0; i < 6; i++) begin
      chk("R10", "ring host address", lg_host[lbase+i],
          (i % 2 == 0) ? 64'h0000_0001_0000_A000 : 64'h0000_0002_0000_B000);
      chk("R5", "ring direction", {63'h0, lg_dir[lbase+i]}, (i % 2 == 0) ? 64'h0 : 64'h1);
    end
    sum = 32'h0;
    for (int i = lbase; i < log_n; i++) sum += lg_bytes[i];
    rd(8'h64, v);
    chk("R11", "byte total matches finished hops", {32'h0, v}, {32'h0, sum});
    rd(8'h60, v);
    chk("R11", "done after abort", {63'h0, v[4]}, 64'h1);
    chk("R8", "ring irq set", {63'h0, v[5]}, 64'h1);
    repeat (50) @(negedge clk);
    chk("R11", "no transfers after abort", 64'(log_n - lbase), 64'(cnt));
    chk("R11", "requests idle after abort", {62'h0, mem_req_valid, xfer_valid}, 64'h0);

    // random chains
    for (int r = 0; r < 25; r++) random_chain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule